// File: doc/BRIEF.md
# Addressed Three-Wire Serial Register Port

This block is the slave side of a three-wire serial link with a chip-enable line, a serial clock line and a data-in line. A host writes the display image and a small set of control fields into holding registers, and reads back a key image and a sleep flag. The block also drives an open-drain data-out line, modelled as a drive-low enable. All three input pins are asynchronous to the system clock. Each one passes through a synchronizer, and the serial clock and chip-enable edges are detected on the system clock.

A transfer begins with an 8-bit address, sent least-significant bit first on rising serial-clock edges while chip enable is low. Chip enable then goes high, and the payload follows on further rising serial-clock edges.
- The write address 42h is followed by a 51-bit frame, and the holding registers take the frame when chip enable falls. A one-bit identifier in the last position selects which half of the 90-bit display image, and which control fields, the frame carries.
- The read address 43h shifts out a snapshot of the key image and the sleep flag.

While chip enable is low, the data-out line works as a key-read request. The display-reset input only stops that request. It never blocks register writes.

Top module: `triwire_regport`

## Requirements
- R1: After the system reset (rst_n low), the display image and all control fields read zero, no strobe pulses, and sdo_low is 0 while key_req is 0.
- R2: An address of 42h (8 clocks, chip enable low) followed by exactly 51 payload bits whose bit 50 is 0 updates the fields when chip enable falls, and load_lo pulses for one cycle. Payload bit i, for i from 0 to 44, goes to disp_img[i]. Bits 45–46 go to sleep_sel, bits 47–48 go to port_sel, and bit 49 goes to seg_off. key_sel is unchanged.
- R3: The same frame with bit 50 equal to 1 updates other fields. Payload bits 0–44 go to disp_img[45+i], and bits 45–46 go to key_sel. Bits 47–49 are ignored. load_hi pulses, and disp_img[44:0], sleep_sel, port_sel and seg_off stay unchanged.
- R4: A write frame with a payload length other than 51 bits changes no register and raises no strobe.
- R5: A payload after an address other than 42h or 43h is ignored. So is a payload after an address phase that has other than exactly 8 clocks.
- R6: After address 43h, the read word is key_img[0] first, through key_img[29], then sleep_ack as bit 30. Each bit is presented before its rising serial clock, with sdo_low = 1 for a 0 bit. Once all 31 bits have been shifted, the line is released (sdo_low = 0).
- R7: rd_done pulses for one cycle after chip enable falls, but only if exactly 31 serial clocks were given in the read payload.
- R8: With chip enable low, sdo_low equals key_req while hold_n is 1, and is 0 while hold_n is 0. With chip enable high and no read in progress, sdo_low is 0.
- R9: Register writes complete normally while hold_n is 0.
- R10: The read word is captured when chip enable rises. Later changes of key_img or sleep_ack do not alter the bits shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| hold_n | input | 1 | Active-low display reset; suppresses only the key-read request |
| ce_pin | input | 1 | Chip enable from host (asynchronous) |
| sclk_pin | input | 1 | Serial clock from host (asynchronous) |
| sdi_pin | input | 1 | Serial data from host (asynchronous) |
| key_img | input | 30 | Key image to be read |
| sleep_ack | input | 1 | Sleep-acknowledge flag to be read |
| key_req | input | 1 | Key-read request from the key logic |
| disp_img | output | 90 | Display image holding register |
| sleep_sel | output | 2 | Sleep control field |
| port_sel | output | 2 | Output-port selection field |
| seg_off | output | 1 | Segment blanking control |
| key_sel | output | 2 | Key-line selection field |
| load_lo | output | 1 | One-cycle strobe: frame 0 taken |
| load_hi | output | 1 | One-cycle strobe: frame 1 taken |
| rd_done | output | 1 | One-cycle strobe: complete read frame finished |
| sdo_low | output | 1 | Open-drain data-out: 1 pulls the line low |

## Verification
Every pin change needs two cycles of synchronizer and one of edge detection. After that, a read bit appears on sdo_low on the third clock edge after a serial-clock rise or chip-enable rise. The holding registers and load strobes change on the fourth edge after chip enable falls, and rd_done rises on the third edge. The bench holds each pin level for six clocks, samples sdo_low just before the next rising serial clock, and checks the registers eighteen clocks after chip enable falls. Strobes are counted by a monitor on the falling clock edge, so a pulse is counted exactly once, whatever its exact cycle.

// File: rtl/twr_pkg.sv
`timescale 1ns/1ps
package twr_pkg;
    // control field width carried by each write frame
    localparam int CTRL_BITS = 5;

    typedef enum logic [1:0] {
        M_IDLE  = 2'd0,
        M_WRITE = 2'd1,
        M_READ  = 2'd2
    } mode_e;
endpackage

// File: rtl/twr_sync.sv
`timescale 1ns/1ps
module twr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lvl = s_q.chain[STAGES-1];
endmodule

// File: rtl/twr_shift.sv
`timescale 1ns/1ps
module twr_shift
    import twr_pkg::*;
#(
    parameter int                 ADDR_W     = 8,
    parameter logic [ADDR_W-1:0]  WR_ADDR    = 'h42,
    parameter logic [ADDR_W-1:0]  RD_ADDR    = 'h43,
    parameter int                 FRAME_BITS = 51,
    parameter int                 RD_BITS    = 31
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ce,
    input  logic                  sck,
    input  logic                  sdi,
    input  logic [RD_BITS-1:0]    rd_word,
    output logic [FRAME_BITS-1:0] frame,
    output logic                  frame_ok,
    output logic                  rd_done,
    output logic                  rd_active,
    output logic                  rd_bit
);
    localparam int MAXLEN = (FRAME_BITS > RD_BITS) ? FRAME_BITS : RD_BITS;
    localparam int CNT_W  = $clog2(MAXLEN + 2);
    localparam int ACNT_W = $clog2(ADDR_W + 2);
    localparam logic [CNT_W-1:0]  CNT_SAT  = CNT_W'(MAXLEN + 1);
    localparam logic [ACNT_W-1:0] ACNT_SAT = ACNT_W'(ADDR_W + 1);
    localparam logic [ACNT_W-1:0] ACNT_OK  = ACNT_W'(ADDR_W);

    typedef struct packed {
        logic                  ce_p;
        logic                  sck_p;
        mode_e                 mode;
        logic [ACNT_W-1:0]     acnt;
        logic [ADDR_W-1:0]     abuf;
        logic [CNT_W-1:0]      pcnt;
        logic [FRAME_BITS-1:0] fbuf;
        logic [RD_BITS-1:0]    rbuf;
        logic                  ok;
        logic                  done;
    } shift_t;

    shift_t s_d, s_q;
    logic   ce_rise, ce_fall, sck_rise, addr_full;

    assign ce_rise   = ce & ~s_q.ce_p;
    assign ce_fall   = ~ce & s_q.ce_p;
    assign sck_rise  = sck & ~s_q.sck_p;
    assign addr_full = (s_q.acnt == ACNT_OK);

    always_comb begin
        s_d       = s_q;
        s_d.ce_p  = ce;
        s_d.sck_p = sck;
        s_d.ok    = 1'b0;
        s_d.done  = 1'b0;
        if (ce_rise) begin
            // address phase closes: choose direction
            s_d.pcnt = '0;
            if (addr_full && s_q.abuf == WR_ADDR) begin
                s_d.mode = M_WRITE;
            end else if (addr_full && s_q.abuf == RD_ADDR) begin
                s_d.mode = M_READ;
                s_d.rbuf = rd_word;
            end else begin
                s_d.mode = M_IDLE;
            end
        end else if (ce_fall) begin
            // frame closes: commit only on exact length
            s_d.ok   = (s_q.mode == M_WRITE) && (s_q.pcnt == CNT_W'(FRAME_BITS));
            s_d.done = (s_q.mode == M_READ)  && (s_q.pcnt == CNT_W'(RD_BITS));
            s_d.mode = M_IDLE;
            s_d.acnt = '0;
        end else if (sck_rise) begin
            if (!ce) begin
                s_d.abuf = {sdi, s_q.abuf[ADDR_W-1:1]};
                if (s_q.acnt != ACNT_SAT) s_d.acnt = s_q.acnt + 1'b1;
            end else if (s_q.mode != M_IDLE) begin
                if (s_q.pcnt != CNT_SAT) s_d.pcnt = s_q.pcnt + 1'b1;
                if (s_q.mode == M_WRITE) s_d.fbuf = {sdi, s_q.fbuf[FRAME_BITS-1:1]};
                else                     s_d.rbuf = {1'b1, s_q.rbuf[RD_BITS-1:1]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign frame     = s_q.fbuf;
    assign frame_ok  = s_q.ok;
    assign rd_done   = s_q.done;
    assign rd_active = (s_q.mode == M_READ);
    assign rd_bit    = s_q.rbuf[0];
endmodule

// File: rtl/twr_regfile.sv
`timescale 1ns/1ps
module twr_regfile
    import twr_pkg::*;
#(
    parameter int SEG_BITS = 45,
    localparam int FRAME_BITS = SEG_BITS + CTRL_BITS + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_ok,
    input  logic [FRAME_BITS-1:0] frame,
    output logic [2*SEG_BITS-1:0] disp,
    output logic [1:0]            sleep_sel,
    output logic [1:0]            port_sel,
    output logic                  seg_off,
    output logic [1:0]            key_sel,
    output logic                  load_lo,
    output logic                  load_hi
);
    typedef struct packed {
        logic [2*SEG_BITS-1:0] disp;
        logic [1:0]            sleep;
        logic [1:0]            port;
        logic                  off;
        logic [1:0]            key;
        logic                  lo;
        logic                  hi;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.lo = 1'b0;
        r_d.hi = 1'b0;
        if (frame_ok) begin
            if (!frame[FRAME_BITS-1]) begin
                r_d.disp[SEG_BITS-1:0] = frame[SEG_BITS-1:0];
                r_d.sleep              = frame[SEG_BITS+1:SEG_BITS];
                r_d.port               = frame[SEG_BITS+3:SEG_BITS+2];
                r_d.off                = frame[SEG_BITS+4];
                r_d.lo                 = 1'b1;
            end else begin
                r_d.disp[2*SEG_BITS-1:SEG_BITS] = frame[SEG_BITS-1:0];
                r_d.key                         = frame[SEG_BITS+1:SEG_BITS];
                r_d.hi                          = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign disp      = r_q.disp;
    assign sleep_sel = r_q.sleep;
    assign port_sel  = r_q.port;
    assign seg_off   = r_q.off;
    assign key_sel   = r_q.key;
    assign load_lo   = r_q.lo;
    assign load_hi   = r_q.hi;
endmodule

// File: rtl/triwire_regport.sv
`timescale 1ns/1ps
module triwire_regport
    import twr_pkg::*;
#(
    parameter int SEG_BITS    = 45,
    parameter int KEY_BITS    = 30,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] WR_ADDR = 'h42,
    parameter logic [ADDR_W-1:0] RD_ADDR = 'h43
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hold_n,
    input  logic                  ce_pin,
    input  logic                  sclk_pin,
    input  logic                  sdi_pin,
    input  logic [KEY_BITS-1:0]   key_img,
    input  logic                  sleep_ack,
    input  logic                  key_req,
    output logic [2*SEG_BITS-1:0] disp_img,
    output logic [1:0]            sleep_sel,
    output logic [1:0]            port_sel,
    output logic                  seg_off,
    output logic [1:0]            key_sel,
    output logic                  load_lo,
    output logic                  load_hi,
    output logic                  rd_done,
    output logic                  sdo_low
);
    localparam int FRAME_BITS = SEG_BITS + CTRL_BITS + 1;
    localparam int RD_BITS    = KEY_BITS + 1;
    localparam int NPINS      = 3;

    logic [NPINS-1:0]      pins_raw, pins_lvl;
    logic                  ce_lvl, sck_lvl, sdi_lvl;
    logic [FRAME_BITS-1:0] frame;
    logic                  frame_ok, rd_active, rd_bit;

    assign pins_raw = {sdi_pin, sclk_pin, ce_pin};

    for (genvar g = 0; g < NPINS; g++) begin : g_sync
        twr_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pins_raw[g]),
            .lvl  (pins_lvl[g])
        );
    end

    assign ce_lvl  = pins_lvl[0];
    assign sck_lvl = pins_lvl[1];
    assign sdi_lvl = pins_lvl[2];

    twr_shift #(
        .ADDR_W    (ADDR_W),
        .WR_ADDR   (WR_ADDR),
        .RD_ADDR   (RD_ADDR),
        .FRAME_BITS(FRAME_BITS),
        .RD_BITS   (RD_BITS)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce       (ce_lvl),
        .sck      (sck_lvl),
        .sdi      (sdi_lvl),
        .rd_word  ({sleep_ack, key_img}),
        .frame    (frame),
        .frame_ok (frame_ok),
        .rd_done  (rd_done),
        .rd_active(rd_active),
        .rd_bit   (rd_bit)
    );

    twr_regfile #(.SEG_BITS(SEG_BITS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_ok (frame_ok),
        .frame    (frame),
        .disp     (disp_img),
        .sleep_sel(sleep_sel),
        .port_sel (port_sel),
        .seg_off  (seg_off),
        .key_sel  (key_sel),
        .load_lo  (load_lo),
        .load_hi  (load_hi)
    );

    // open-drain data-out: request line while deselected, read data while reading
    always_comb begin
        if (ce_lvl) sdo_low = rd_active & ~rd_bit;
        else        sdo_low = key_req & hold_n;
    end
endmodule

// File: rtl/twr_checks.sv
`timescale 1ns/1ps
module twr_checks #(
    parameter int DISP_W = 90
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hold_n,
    input logic              ce_lvl,
    input logic              rd_active,
    input logic              sdo_low,
    input logic              load_lo,
    input logic              load_hi,
    input logic              rd_done,
    input logic [DISP_W-1:0] disp_img,
    input logic [1:0]        sleep_sel,
    input logic [1:0]        port_sel,
    input logic              seg_off,
    input logic [1:0]        key_sel
);
    assert_strobe_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_lo && load_hi));

    assert_disp_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_lo || load_hi) |-> $stable(disp_img));

    assert_ctrl_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_hi |-> ($stable(sleep_sel) && $stable(port_sel) && $stable(seg_off)));

    assert_keysel_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_lo |-> $stable(key_sel));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

    assert_hold_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_n && !ce_lvl) |-> !sdo_low);

    assert_idle_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_lvl && !rd_active) |-> !sdo_low);
endmodule

bind triwire_regport twr_checks #(.DISP_W(2*SEG_BITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_n   (hold_n),
    .ce_lvl   (ce_lvl),
    .rd_active(rd_active),
    .sdo_low  (sdo_low),
    .load_lo  (load_lo),
    .load_hi  (load_hi),
    .rd_done  (rd_done),
    .disp_img (disp_img),
    .sleep_sel(sleep_sel),
    .port_sel (port_sel),
    .seg_off  (seg_off),
    .key_sel  (key_sel)
);

// File: tb/triwire_regport_test.sv
`timescale 1ns/1ps
module triwire_regport_test;
    localparam int SEG  = 45;
    localparam int KEYS = 30;
    localparam int HALF = 6;
    localparam int NV   = 8;

    // entry: {addr[7:0], addr_clocks[3:0], payload_bits[6:0], frame_id, disp[44:0], ctrl[4:0]}
    localparam logic [69:0] VEC [NV] = '{
        {8'h42, 4'd8, 7'd51, 1'b0, 45'h12345_6789AB,  5'b10110},
        {8'h42, 4'd8, 7'd51, 1'b1, 45'h0F0F0F0F0F0F, 5'b00011},
        {8'h42, 4'd8, 7'd50, 1'b0, 45'h1FFFFFFFFFFF, 5'b11111},
        {8'h42, 4'd8, 7'd52, 1'b1, 45'h1FFFFFFFFFFF, 5'b11111},
        {8'h44, 4'd8, 7'd51, 1'b0, 45'h1FFFFFFFFFFF, 5'b11111},
        {8'h42, 4'd9, 7'd51, 1'b0, 45'h1FFFFFFFFFFF, 5'b11111},
        {8'h42, 4'd7, 7'd51, 1'b1, 45'h1FFFFFFFFFFF, 5'b11111},
        {8'h42, 4'd8, 7'd51, 1'b0, 45'h0,            5'b01001}
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n, hold_n, ce, sclk, sdi, sleep_ack, key_req;
    logic [KEYS-1:0]   key_img;
    logic [2*SEG-1:0]  disp_img;
    logic [1:0]        sleep_sel, port_sel, key_sel;
    logic              seg_off, load_lo, load_hi, rd_done, sdo_low;

    triwire_regport uut (
        .clk(clk), .rst_n(rst_n), .hold_n(hold_n),
        .ce_pin(ce), .sclk_pin(sclk), .sdi_pin(sdi),
        .key_img(key_img), .sleep_ack(sleep_ack), .key_req(key_req),
        .disp_img(disp_img), .sleep_sel(sleep_sel), .port_sel(port_sel),
        .seg_off(seg_off), .key_sel(key_sel), .load_lo(load_lo),
        .load_hi(load_hi), .rd_done(rd_done), .sdo_low(sdo_low)
    );

    int n_chk = 0, n_bad = 0;
    int n_lo = 0, n_hi = 0, n_done = 0;
    bit finished = 1'b0;

    logic [2*SEG-1:0] m_disp = '0;
    logic [1:0]       m_sleep = '0, m_port = '0, m_key = '0;
    logic             m_off = 1'b0;

    always @(negedge clk) begin
        if (load_lo) n_lo++;
        if (load_hi) n_hi++;
        if (rd_done) n_done++;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic bit_out(input logic b);
        sdi = b;
        tick(HALF);
        sclk = 1'b1;
        tick(HALF);
        sclk = 1'b0;
    endtask

    task automatic send_addr(input logic [7:0] a, input int n);
        for (int i = 0; i < n; i++) bit_out(i < 8 ? a[i] : 1'b0);
    endtask

    task automatic write_frame(input logic [7:0] a, input int aclk,
                               input logic [63:0] pl, input int nb);
        send_addr(a, aclk);
        ce = 1'b1;
        tick(HALF);
        for (int i = 0; i < nb; i++) bit_out(pl[i]);
        tick(HALF);
        ce = 1'b0;
        tick(3 * HALF);
    endtask

    task automatic read_frame(input int nclk, output logic [31:0] got);
        got = '1;
        send_addr(8'h43, 8);
        ce = 1'b1;
        tick(HALF);
        for (int i = 0; i < nclk; i++) begin
            got[i] = ~sdo_low;
            bit_out(1'b0);
        end
        tick(HALF);
        ce = 1'b0;
        tick(3 * HALF);
    endtask

    task automatic check_regs(input string req);
        chk(req, 128'(disp_img),  128'(m_disp));
        chk(req, 128'(sleep_sel), 128'(m_sleep));
        chk(req, 128'(port_sel),  128'(m_port));
        chk(req, 128'(seg_off),   128'(m_off));
        chk(req, 128'(key_sel),   128'(m_key));
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog act=hung exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] got;
        logic [31:0] want;
        int lo0, hi0, dn0;

        rst_n = 1'b0; hold_n = 1'b1; ce = 1'b0; sclk = 1'b0; sdi = 1'b0;
        key_img = '0; sleep_ack = 1'b0; key_req = 1'b0;
        tick(5);
        rst_n = 1'b1;
        tick(4);

        // R1: reset state
        check_regs("R1");
        chk("R1", 128'(sdo_low), 128'(0));
        chk("R1", 128'(n_lo + n_hi + n_done), 128'(0));

        // vector table: write frames, valid and rejected
        for (int v = 0; v < NV; v++) begin
            logic [7:0]  a;
            logic [3:0]  ac;
            logic [6:0]  nb;
            logic        id;
            logic [44:0] dd;
            logic [4:0]  ct;
            logic [63:0] pl;
            bit          good;
            string       req;
            {a, ac, nb, id, dd, ct} = VEC[v];
            pl = {13'd0, id, ct, dd};
            good = (a == 8'h42) && (ac == 4'd8) && (nb == 7'd51);
            if (good)                          req = id ? "R3" : "R2";
            else if (a != 8'h42 || ac != 4'd8) req = "R5";
            else                               req = "R4";
            lo0 = n_lo; hi0 = n_hi;
            write_frame(a, int'(ac), pl, int'(nb));
            if (good && !id) begin
                m_disp[SEG-1:0] = dd;
                m_sleep = ct[1:0]; m_port = ct[3:2]; m_off = ct[4];
            end else if (good) begin
                m_disp[2*SEG-1:SEG] = dd;
                m_key = ct[1:0];
            end
            check_regs(req);
            chk(req, 128'(n_lo - lo0), 128'((good && !id) ? 1 : 0));
            chk(req, 128'(n_hi - hi0), 128'((good && id) ? 1 : 0));
        end

        // R8 / R9: display reset held low
        hold_n = 1'b0;
        key_req = 1'b1;
        tick(2);
        chk("R8", 128'(sdo_low), 128'(0));
        lo0 = n_lo;
        write_frame(8'h42, 8, {13'd0, 1'b0, 5'b11010, 45'h0ABCDE012345}, 51);
        m_disp[SEG-1:0] = 45'h0ABCDE012345;
        m_sleep = 2'b10; m_port = 2'b10; m_off = 1'b1;
        check_regs("R9");
        chk("R9", 128'(n_lo - lo0), 128'(1));
        hold_n = 1'b1;
        tick(2);
        chk("R8", 128'(sdo_low), 128'(1));

        // R8: chip enable high with no read releases the line
        ce = 1'b1;
        tick(HALF);
        chk("R8", 128'(sdo_low), 128'(0));
        ce = 1'b0;
        tick(3 * HALF);
        chk("R8", 128'(sdo_low), 128'(1));
        key_req = 1'b0;
        tick(2);
        check_regs("R5");

        // R6 / R7: complete read frame
        key_img = 30'h1AC35F01;
        sleep_ack = 1'b1;
        dn0 = n_done;
        read_frame(31, got);
        want = {1'b1, 1'b1, 30'h1AC35F01};
        chk("R6", 128'(got[30:0]), 128'(want[30:0]));
        chk("R7", 128'(n_done - dn0), 128'(1));

        // R10: key image changes in mid-frame
        key_img = 30'h2468ACE1;
        sleep_ack = 1'b0;
        dn0 = n_done;
        fork
            read_frame(31, got);
            begin
                tick(8 * 2 * HALF + 5 * HALF);
                key_img = 30'h3FFFFFFF;
                sleep_ack = 1'b1;
            end
        join
        chk("R10", 128'(got[30:0]), 128'({1'b0, 30'h2468ACE1}));
        chk("R7", 128'(n_done - dn0), 128'(1));

        // R6 / R7: clock past the end, line released, no done
        key_img = 30'h0;
        sleep_ack = 1'b0;
        dn0 = n_done;
        read_frame(32, got);
        chk("R6", 128'(got[31]), 128'(1));
        chk("R6", 128'(got[30:0]), 128'(0));
        chk("R7", 128'(n_done - dn0), 128'(0));

        // R7: short read gives no done
        dn0 = n_done;
        read_frame(20, got);
        chk("R7", 128'(n_done - dn0), 128'(0));
        check_regs("R5");

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule